// File: doc/BRIEF.md
# Binary Dense XOR-Popcount Accumulator

This block evaluates one fully connected neuron of a binarized network at a time. Activations and weights are single bits, where a 1 stands for +1 and a 0 stands for -1. Each accepted beat carries `FIN` activation words and `FIN` weight words of `WORD_W` bits each. The block XORs the two vectors, counts the mismatching bit positions, and adds the resulting ±1 dot-product contribution to an integer accumulator.

When the last beat of a neuron arrives, the block captures the running total. It then applies a signed 16-bit scale `k` and offset `h` to that total. One cycle later it emits the sign of `k*sum + h` as a single output bit, together with a result strobe and the exact dot product. The accumulator restarts at once, so the next neuron's beats may follow with no gap.

A neuron ends on a beat marked as last. It also ends once a runtime beat count is reached, if that count is nonzero.

Top module: `bdx_dense_acc`

## Requirements
- R1: After reset, `out_valid`, `out_bit` and `out_sum` are all 0, and they stay 0 until a neuron has finished.
- R2: A beat adds `FIN*WORD_W - 2*popcount(in_data ^ in_weight)` to the neuron's total. This is the sum over all bit positions of +1 where the data and weight bits are equal, and -1 where they differ.
- R3: `out_sum` equals the sum of the contributions of every accepted beat of the neuron, as a two's-complement signed value.
- R4: A beat with `in_valid=1` and `in_last=1` is the final beat of the current neuron.
- R5: When `cfg_beats` is nonzero, the beat numbered `cfg_beats` within a neuron (counting from 1) is its final beat even if `in_last=0`. When `cfg_beats=0`, only `in_last` ends a neuron.
- R6: In a cycle with `in_valid=0`, `in_data`, `in_weight` and `in_last` have no effect on the total or on the beat count.
- R7: `out_valid` is high for exactly one cycle per neuron. It rises at the clock edge that follows the edge at which the final beat is accepted, and it is never high otherwise.
- R8: `out_bit` is 1 when `k*out_sum + h >= 0` and 0 otherwise. Here `k=coef_k` and `h=coef_h` are signed 16-bit values sampled on the final beat of the neuron.
- R9: The next neuron's total starts at zero. A beat in the cycle directly after a final beat belongs to the new neuron.
- R10: Totals over up to `MAX_ELEMS` bits (8192 by default) are exact, including ±`MAX_ELEMS`, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_last | input | 1 | Marks the final beat of a neuron |
| in_data | input | FIN*WORD_W | Binary activations, 1 = +1 |
| in_weight | input | FIN*WORD_W | Binary weights, 1 = +1 |
| cfg_beats | input | CNT_W | Beats per neuron; 0 = use `in_last` only |
| coef_k | input | 16 | Signed scale, sampled on the final beat |
| coef_h | input | 16 | Signed offset, sampled on the final beat |
| out_valid | output | 1 | One-cycle result strobe |
| out_bit | output | 1 | Binarized neuron output, 1 = +1 |
| out_sum | output | ACC_W | Signed dot product of the finished neuron |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **All-agree and all-disagree vectors.** A swapped XOR sense or a missing factor of two would flip or halve the result.
- **Idle cycles carrying garbage data and a raised last flag.** A design that does not gate on `in_valid` would fold in extra terms or end the neuron early.
- **Count-terminated neurons, and single-beat neurons sent back to back.** An off-by-one beat counter, or an accumulator cleared one cycle late, would merge or split neurons and shift the result strobe.
- **Full-length vectors at +8192 and -8192, and affine results of exactly -1 and 0.** An accumulator that is too narrow, or a threshold that treats zero as negative, would give the wrong sign.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

   // Width of the affine scale and offset.
   localparam int COEF_W = 16;

   // Signed width able to hold +/- max_elems exactly.
   function automatic int acc_width(input int max_elems);
      return $clog2(max_elems + 1) + 1;
   endfunction

   // Number of beats needed to cover max_elems bits.
   function automatic int beat_limit(input int max_elems, input int bits);
      return (max_elems + bits - 1) / bits;
   endfunction

endpackage

// File: rtl/bdx_xorpop.sv
// Per-beat contribution: BITS - 2*popcount(data ^ weight).
module bdx_xorpop #(
   parameter int FIN    = 8,
   parameter int WORD_W = 32,
   parameter int ACC_W  = 15,
   // 0: one ripple count per word; 1: pairwise halves per word
   parameter int POP_STYLE = 0
) (
   input  logic [FIN*WORD_W-1:0]   data_i,
   input  logic [FIN*WORD_W-1:0]   weight_i,
   output logic signed [ACC_W-1:0] contrib_o
);
   localparam int BITS   = FIN * WORD_W;
   localparam int WPOP_W = $clog2(WORD_W + 1);
   localparam int POP_W  = $clog2(BITS + 1);
   localparam int HALF_W = WORD_W / 2;

   logic [FIN*WPOP_W-1:0] word_pop;
   logic [POP_W-1:0]      total_pop;
   logic [ACC_W-1:0]      diff_u;

   for (genvar g = 0; g < FIN; g++) begin : g_word
      logic [WORD_W-1:0] mism;
      logic [WPOP_W-1:0] cnt;
      assign mism = data_i[g*WORD_W +: WORD_W] ^ weight_i[g*WORD_W +: WORD_W];

      if (POP_STYLE == 1 && WORD_W >= 2) begin : g_split
         logic [WPOP_W-1:0] lo_cnt, hi_cnt;
         always_comb begin
            lo_cnt = '0;
            hi_cnt = '0;
            for (int b = 0; b < HALF_W; b++) begin
               lo_cnt = lo_cnt + WPOP_W'(mism[b]);
            end
            for (int b = HALF_W; b < WORD_W; b++) begin
               hi_cnt = hi_cnt + WPOP_W'(mism[b]);
            end
         end
         assign cnt = lo_cnt + hi_cnt;
      end else begin : g_ripple
         always_comb begin
            cnt = '0;
            for (int b = 0; b < WORD_W; b++) begin
               cnt = cnt + WPOP_W'(mism[b]);
            end
         end
      end

      assign word_pop[g*WPOP_W +: WPOP_W] = cnt;
   end

   always_comb begin
      total_pop = '0;
      for (int g = 0; g < FIN; g++) begin
         total_pop = total_pop + POP_W'(word_pop[g*WPOP_W +: WPOP_W]);
      end
   end

   assign diff_u    = ACC_W'(BITS) - (ACC_W'(total_pop) << 1);
   assign contrib_o = $signed(diff_u);

   // R2: a contribution always lies in [-BITS, BITS] and has BITS' parity
   always_comb begin
      a_contrib_range_r2 : assert ((contrib_o >= -BITS) && (contrib_o <= BITS));
   end

endmodule

// File: rtl/bdx_accum.sv
// Neuron accumulator with a beat counter and end-of-neuron detection.
module bdx_accum #(
   parameter int ACC_W     = 15,
   parameter int CNT_W     = 10,
   parameter int BITS      = 256,
   parameter int MAX_ELEMS = 8192
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid_i,
   input  logic                    in_last_i,
   input  logic signed [ACC_W-1:0] contrib_i,
   input  logic [CNT_W-1:0]        cfg_beats_i,
   output logic                    end_beat_o,
   output logic                    fin_vld_o,
   output logic signed [ACC_W-1:0] fin_sum_o
);
   logic signed [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [CNT_W-1:0]        cnt_inc;
   logic                    count_hit;
   logic signed [ACC_W-1:0] acc_sum;

   assign cnt_inc    = cnt_q + CNT_W'(1);
   assign count_hit  = (cfg_beats_i != '0) && (cnt_inc == cfg_beats_i);
   assign end_beat_o = in_valid_i && (in_last_i || count_hit);
   assign acc_sum    = acc_q + contrib_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         cnt_q     <= '0;
         fin_vld_o <= 1'b0;
         fin_sum_o <= '0;
      end else begin
         fin_vld_o <= end_beat_o;
         if (end_beat_o) begin
            fin_sum_o <= acc_sum;
            acc_q     <= '0;
            cnt_q     <= '0;
         end else if (in_valid_i) begin
            acc_q <= acc_sum;
            cnt_q <= cnt_inc;
         end
      end
   end

   // R6: idle cycles leave the running state untouched
   p_idle_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid_i |=> ($stable(acc_q) && $stable(cnt_q) && !fin_vld_o));

   // R9: the cycle after a final beat starts from an empty accumulator
   p_restart_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      end_beat_o |=> (acc_q == '0 && cnt_q == '0 && fin_vld_o));

   // R10: the running total never exceeds the bits seen so far
   p_acc_bound_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acc_q) <= int'(cnt_q) * BITS) && (int'(acc_q) >= -(int'(cnt_q) * BITS)));

endmodule

// File: rtl/bdx_affine.sv
// Applies k*sum + h to a finished total and registers its sign.
module bdx_affine #(
   parameter int ACC_W     = 15,
   parameter int COEF_W    = 16,
   parameter int MAX_ELEMS = 8192
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fin_vld_i,
   input  logic signed [ACC_W-1:0]  fin_sum_i,
   input  logic signed [COEF_W-1:0] coef_k_i,
   input  logic signed [COEF_W-1:0] coef_h_i,
   output logic                     out_valid_o,
   output logic                     out_bit_o,
   output logic signed [ACC_W-1:0]  out_sum_o
);
   localparam int Y_W = ACC_W + COEF_W + 1;

   logic signed [Y_W-1:0] k_x, s_x, h_x, y_val;

   assign k_x   = Y_W'(coef_k_i);
   assign s_x   = Y_W'(fin_sum_i);
   assign h_x   = Y_W'(coef_h_i);
   assign y_val = k_x * s_x + h_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_bit_o   <= 1'b0;
         out_sum_o   <= '0;
      end else begin
         out_valid_o <= fin_vld_i;
         if (fin_vld_i) begin
            out_bit_o <= ~y_val[Y_W-1];
            out_sum_o <= fin_sum_i;
         end
      end
   end

   // R7: a finished total produces a strobe on the next edge
   p_strobe_follows_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      fin_vld_i |=> out_valid_o);

   // R7: no strobe without a finished total
   p_no_spurious_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !fin_vld_i |=> !out_valid_o);

   // R10: a reported total stays within the supported vector length
   p_sum_range_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (int'(out_sum_o) <= MAX_ELEMS && int'(out_sum_o) >= -MAX_ELEMS));

endmodule

// File: rtl/bdx_dense_acc.sv
module bdx_dense_acc
   import bdx_pkg::*;
#(
   parameter int FIN       = 8,
   parameter int WORD_W    = 32,
   parameter int MAX_ELEMS = 8192,
   parameter int POP_STYLE = 0,
   localparam int BITS      = FIN * WORD_W,
   localparam int ACC_W     = acc_width(MAX_ELEMS),
   localparam int MAX_BEATS = beat_limit(MAX_ELEMS, FIN * WORD_W),
   localparam int CNT_W     = $clog2(MAX_BEATS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_last,
   input  logic [BITS-1:0]          in_data,
   input  logic [BITS-1:0]          in_weight,
   input  logic [CNT_W-1:0]         cfg_beats,
   input  logic signed [COEF_W-1:0] coef_k,
   input  logic signed [COEF_W-1:0] coef_h,
   output logic                     out_valid,
   output logic                     out_bit,
   output logic signed [ACC_W-1:0]  out_sum
);
   // Elaboration-time parameter checks
   if (FIN < 1) begin : g_bad_fin
      $error("bdx_dense_acc: FIN must be at least 1");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("bdx_dense_acc: WORD_W must be at least 1");
   end
   if (MAX_ELEMS < BITS) begin : g_bad_len
      $error("bdx_dense_acc: MAX_ELEMS must cover one beat");
   end
   if (POP_STYLE != 0 && POP_STYLE != 1) begin : g_bad_style
      $error("bdx_dense_acc: POP_STYLE must be 0 or 1");
   end

   logic signed [ACC_W-1:0]  contrib;
   logic                     end_beat;
   logic                     fin_vld;
   logic signed [ACC_W-1:0]  fin_sum;
   logic signed [COEF_W-1:0] k_q, h_q;

   bdx_xorpop #(
      .FIN(FIN), .WORD_W(WORD_W), .ACC_W(ACC_W), .POP_STYLE(POP_STYLE)
   ) i_xorpop (
      .data_i(in_data), .weight_i(in_weight), .contrib_o(contrib)
   );

   bdx_accum #(
      .ACC_W(ACC_W), .CNT_W(CNT_W), .BITS(BITS), .MAX_ELEMS(MAX_ELEMS)
   ) i_accum (
      .clk(clk), .rst_n(rst_n),
      .in_valid_i(in_valid), .in_last_i(in_last),
      .contrib_i(contrib), .cfg_beats_i(cfg_beats),
      .end_beat_o(end_beat), .fin_vld_o(fin_vld), .fin_sum_o(fin_sum)
   );

   // R8: the coefficients are captured together with the final beat
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_q <= '0;
         h_q <= '0;
      end else if (end_beat) begin
         k_q <= coef_k;
         h_q <= coef_h;
      end
   end

   bdx_affine #(
      .ACC_W(ACC_W), .COEF_W(COEF_W), .MAX_ELEMS(MAX_ELEMS)
   ) i_affine (
      .clk(clk), .rst_n(rst_n),
      .fin_vld_i(fin_vld), .fin_sum_i(fin_sum),
      .coef_k_i(k_q), .coef_h_i(h_q),
      .out_valid_o(out_valid), .out_bit_o(out_bit), .out_sum_o(out_sum)
   );

   // R8: coefficients hold between final beats
   p_coef_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !end_beat |=> ($stable(k_q) && $stable(h_q)));

endmodule

// File: tb/test_bdx_dense_acc.sv
module test_bdx_dense_acc;
   import bdx_pkg::*;

   localparam int FIN       = 2;
   localparam int WORD_W    = 8;
   localparam int MAX_ELEMS = 8192;
   localparam int BW        = FIN * WORD_W;
   localparam int ACC_W     = acc_width(MAX_ELEMS);
   localparam int CNT_W     = $clog2(beat_limit(MAX_ELEMS, BW) + 1);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic                     in_valid = 1'b0;
   logic                     in_last = 1'b0;
   logic [BW-1:0]            in_data = '0;
   logic [BW-1:0]            in_weight = '0;
   logic [CNT_W-1:0]         cfg_beats = '0;
   logic signed [15:0]       coef_k = '0;
   logic signed [15:0]       coef_h = '0;
   logic                     out_valid;
   logic                     out_bit;
   logic signed [ACC_W-1:0]  out_sum;

   always #4 clk = ~clk;  // 125 MHz

   bdx_dense_acc #(.FIN(FIN), .WORD_W(WORD_W), .MAX_ELEMS(MAX_ELEMS)) i_bdx_dense_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_data(in_data), .in_weight(in_weight), .cfg_beats(cfg_beats),
      .coef_k(coef_k), .coef_h(coef_h),
      .out_valid(out_valid), .out_bit(out_bit), .out_sum(out_sum)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int acc_m    = 0;
   bit finished = 1'b0;
   int q_sum[$];
   int q_bit[$];
   int q_cyc[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference: +1 per agreeing bit, -1 per differing bit
   function automatic int model_dot(input logic [BW-1:0] d, input logic [BW-1:0] w);
      int s = 0;
      for (int i = 0; i < BW; i++) s += (d[i] == w[i]) ? 1 : -1;
      return s;
   endfunction

   // Result monitor: checks sum (R3), sign (R8) and strobe cycle (R7)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q_sum.size() == 0) begin
            chk(1'b0, "R7 unexpected strobe", 1, 0);
         end else begin
            int es, eb, ec;
            es = q_sum.pop_front();
            eb = q_bit.pop_front();
            ec = q_cyc.pop_front();
            chk(int'(out_sum) == es, "R3 sum", out_sum, es);
            chk(int'(out_bit) == eb, "R8 sign", out_bit, eb);
            chk(cyc == ec, "R7 strobe cycle", cyc, ec);
         end
      end
   end

   // Drive one accepted beat; fin marks the bench's view of the neuron end
   task automatic beat(input logic [BW-1:0] d, input logic [BW-1:0] w, input logic last,
                       input bit fin, input int k = 1, input int h = 0);
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = d;
      in_weight = w;
      in_last   = last;
      coef_k    = 16'(k);
      coef_h    = 16'(h);
      acc_m    += model_dot(d, w);
      if (fin) begin
         longint y;
         y = longint'(k) * longint'(acc_m) + longint'(h);
         q_sum.push_back(acc_m);
         q_bit.push_back((y >= 0) ? 1 : 0);
         q_cyc.push_back(cyc + 2);
         acc_m = 0;
      end
   endtask

   // Idle cycle with garbage on the qualified inputs
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_last   = 1'(i % 2 == 0);
         in_data   = BW'($urandom);
         in_weight = BW'($urandom);
      end
   endtask

   task automatic drain(input string tag);
      idle(3);
      chk(q_sum.size() == 0, tag, q_sum.size(), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
      chk(out_bit == 1'b0, "R1 out_bit in reset", out_bit, 0);
      chk(out_sum == '0, "R1 out_sum in reset", out_sum, 0);
      rst_n = 1'b1;
      idle(4);
      chk(out_valid == 1'b0, "R1 out_valid idle after reset", out_valid, 0);
      chk(out_sum == '0, "R1 out_sum idle after reset", out_sum, 0);
   endtask

   task automatic t_single_extremes();
      // R2: all agree gives +BW, all differ gives -BW
      beat(16'hA5C3, 16'hA5C3, 1'b1, 1'b1);
      idle(1);
      beat(16'h0F0F, 16'hF0F0, 1'b1, 1'b1);
      beat(16'h00FF, 16'h0000, 1'b1, 1'b1);  // R2 half agree: 0
      drain("R2 results outstanding");
   endtask

   task automatic t_multi_beat();
      // R3 / R4: four beats ended by in_last
      for (int i = 0; i < 4; i++) begin
         beat(BW'($urandom), BW'($urandom), 1'(i == 3), i == 3, 3, -5);
      end
      drain("R4 results outstanding");
   endtask

   task automatic t_gaps();
      // R6: garbage and raised last while in_valid is low
      beat(16'h1234, 16'h1234, 1'b0, 1'b0, 1, 0);
      idle(3);
      beat(16'hFFFF, 16'h0000, 1'b0, 1'b0, 1, 0);
      idle(2);
      beat(16'h5555, 16'h5554, 1'b1, 1'b1, 1, 0);
      drain("R6 results outstanding");
   endtask

   task automatic t_count_mode();
      // R5: three beats end the neuron without in_last
      @(negedge clk);
      cfg_beats = CNT_W'(3);
      for (int n = 0; n < 2; n++) begin
         for (int i = 0; i < 3; i++) begin
            beat(BW'($urandom), BW'($urandom), 1'b0, i == 2, -2, 7);
         end
      end
      // R5: in_last still ends a neuron before the count
      beat(16'hAAAA, 16'hAAAA, 1'b1, 1'b1);
      drain("R5 results outstanding");
      @(negedge clk);
      cfg_beats = '0;
      // R5: count of zero means only in_last ends a neuron
      for (int i = 0; i < 5; i++) begin
         beat(BW'($urandom), BW'($urandom), 1'(i == 4), i == 4);
      end
      drain("R5 zero count results outstanding");
   endtask

   task automatic t_back_to_back();
      // R9: single-beat neurons on consecutive cycles
      beat(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
      beat(16'hFFFF, 16'h0000, 1'b1, 1'b1);
      beat(16'hF000, 16'hF0F0, 1'b1, 1'b1);
      beat(16'h0001, 16'h0001, 1'b0, 1'b0);
      beat(16'h0001, 16'h0001, 1'b1, 1'b1);
      drain("R9 results outstanding");
   endtask

   task automatic t_affine();
      // R8: sum 0 with h 0 gives y=0, sign bit 1
      beat(16'h00FF, 16'h0000, 1'b1, 1'b1, 5, 0);
      // R8: sum 16, k=-3: h=47 gives -1 (bit 0), h=48 gives 0 (bit 1)
      beat(16'h1111, 16'h1111, 1'b1, 1'b1, -3, 47);
      beat(16'h1111, 16'h1111, 1'b1, 1'b1, -3, 48);
      // R8: sum -16 with k=1, h=16 gives 0
      beat(16'h0000, 16'hFFFF, 1'b1, 1'b1, 1, 16);
      drain("R8 results outstanding");
   endtask

   task automatic t_max_len();
      // R10: a full-length vector of agreements then one of disagreements
      @(negedge clk);
      cfg_beats = CNT_W'(MAX_ELEMS / BW);
      for (int i = 0; i < MAX_ELEMS / BW; i++) begin
         beat(16'h3C3C, 16'h3C3C, 1'b0, i == MAX_ELEMS / BW - 1, -32768, 32767);
      end
      for (int i = 0; i < MAX_ELEMS / BW; i++) begin
         logic [BW-1:0] d;
         d = BW'($urandom);
         beat(d, ~d, 1'(i == MAX_ELEMS / BW - 1), i == MAX_ELEMS / BW - 1, 1, 8191);
      end
      drain("R10 results outstanding");
      @(negedge clk);
      cfg_beats = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_single_extremes();
      t_multi_beat();
      t_gaps();
      t_count_mode();
      t_back_to_back();
      t_affine();
      t_max_len();
      idle(5);
      chk(out_valid == 1'b0, "R7 no strobe while idle", out_valid, 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", cyc, 0);
      finish_run();
   end

endmodule